// File: doc/BRIEF.md
# QPSK Symbol Source Selector with Predistortion Taps

This block produces the pair of logic levels (I, Q) that a QPSK modulator turns into one of four carrier phases in each symbol period. A 3-bit mode input chooses where each symbol comes from. The choices are dibits supplied from outside by a serializer, an internal maximal-length pseudo-random sequence, two rotating patterns that offset the carrier by plus or minus a quarter of the symbol rate when the modulator is being aligned, and a fixed level that leaves only the unmodulated carrier.

The chosen dibit passes through two clocked register stages, and both stages load only on a one-cycle symbol strobe. The first stage drives the correction outputs through inverters. The second stage drives the main outputs. As a result the correction outputs always show the inverse of the symbol that the main outputs will show one symbol later. An external resistor network weights these correction levels and sums them with the main levels to pre-compensate the step response of the transmit filter. That analog network is not part of this block.

Top module: `qpsk_symbol_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, the main outputs {I,Q} are 2'b00 and the correction outputs {I*,Q*} are 2'b11.
- R2: The outputs change only in the clock cycle that follows a cycle in which the symbol strobe is high. Between strobes they hold their values.
- R3: At each strobe, the correction outputs take the bitwise inverse of the dibit selected at that strobe. The main outputs take the dibit selected at the previous strobe. So {I*,Q*} equals the inverse of the value that {I,Q} shows one symbol later.
- R4: Mode code 0, and the unused codes 5, 6 and 7, select the constant dibit 2'b00. Under these codes the outputs settle to {I,Q}=2'b00 and {I*,Q*}=2'b11.
- R5: Mode code 1 (lead) steps the dibit {I,Q} through 00, 01, 11, 10 and then repeats, advancing once per strobe. On entry from a non-rotating mode the pattern starts at 00.
- R6: Mode code 2 (lag) steps the dibit {I,Q} through 00, 10, 11, 01 and then repeats, advancing once per strobe. On entry from a non-rotating mode the pattern starts at 00.
- R7: Mode code 3 selects a serial sequence from a 15-bit shift register with polynomial x^15 + x^14 + 1. The register is loaded with SEED at reset. Each output bit is the register's top bit; the register then shifts left and the XOR of its top two bits enters at the bottom. The register advances two bits on every strobe in every mode. Of the two bits taken at a strobe, the earlier one is I and the later one is Q.
- R8: The pseudo-random dibit stream repeats with a period of exactly 32767 strobes.
- R9: Mode code 4 passes the external inputs through, with ext_i going to I and ext_q going to Q, sampled at the strobe.
- R10: The mode and the external inputs are sampled only at a strobe. Values they hold between strobes have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_en | input | 1 | One-cycle symbol strobe |
| mode | input | 3 | Source select code |
| ext_i | input | 1 | External I bit |
| ext_q | input | 1 | External Q bit |
| out_i | output | 1 | Main I level |
| out_q | output | 1 | Main Q level |
| pre_i | output | 1 | Inverted, one-symbol-early I correction |
| pre_q | output | 1 | Inverted, one-symbol-early Q correction |

## Verification
The bench uses the default SEED of 1. That makes the pseudo-random stream after reset predictable from the stated polynomial alone. The bench strobes on every cycle while the pseudo-random source is selected, so a full 32767-symbol period fits inside the run and the repeat point itself can be compared. In the other scenarios the strobe is spaced out, so that mode and external changes made between strobes are shown to have no effect.

// File: rtl/qsm_pkg.sv
// Shared types for the QPSK symbol selector.
// Assumes: the mode code is 3 bits wide and a dibit is carried as {i,q}.
package qsm_pkg;
    localparam int LFSR_W = 15;
    localparam int PH_W   = 2;

    typedef enum logic [2:0] {
        MODE_CW   = 3'd0,
        MODE_LEAD = 3'd1,
        MODE_LAG  = 3'd2,
        MODE_PRBS = 3'd3,
        MODE_EXT  = 3'd4
    } qsm_mode_e;

    typedef struct packed {
        logic i;
        logic q;
    } dibit_t;
endpackage

// File: rtl/qsm_prbs.sv
// Two-bits-per-symbol generator for the sequence x^15 + x^14 + 1.
// Assumes: SEED is nonzero. The earlier serial bit is I and the later bit is Q.
module qsm_prbs
    import qsm_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 15'h0001
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    output dibit_t dib
);
    logic [LFSR_W-1:0] st;

    // Advance the register by two serial steps on each symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= SEED;
        else if (adv)
            st <= {st[LFSR_W-3:0], st[LFSR_W-1] ^ st[LFSR_W-2],
                   st[LFSR_W-2] ^ st[LFSR_W-3]};
    end

    // Present the next two serial bits as a dibit.
    always_comb begin
        dib.i = st[LFSR_W-1];
        dib.q = st[LFSR_W-2];
    end

    // R8
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st != '0);
endmodule

// File: rtl/qsm_rotator.sv
// Quarter-turn phase stepper used for the lead and lag alignment patterns.
// Assumes: while not running, the phase is parked at zero so that the pattern starts at 00.
module qsm_rotator
    import qsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  logic   run,
    input  logic   dir_lag,
    output dibit_t dib
);
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] idx;

    // Step the phase per symbol while running, otherwise park it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else if (adv)
            ph <= run ? ph + 1'b1 : '0;
    end

    // Map the phase to a Gray-coded point, reversing the direction for lag.
    always_comb begin
        idx   = dir_lag ? (~ph + 1'b1) : ph;
        dib.i = idx[1];
        dib.q = idx[1] ^ idx[0];
    end

    // R5
    rot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !run) |=> (dib == 2'b00));
endmodule

// File: rtl/qsm_out_stage.sv
// Two symbol-strobed register stages. The first stage drives the inverted correction taps
// and the second stage drives the main levels, which lag the taps by exactly one symbol.
// Assumes: adv is high for one cycle per symbol.
module qsm_out_stage
    import qsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  dibit_t nxt,
    output logic   out_i,
    output logic   out_q,
    output logic   pre_i,
    output logic   pre_q
);
    dibit_t s1, s2;

    // Load the early stage, then the late stage, on each symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else if (adv) begin
            s1 <= nxt;
            s2 <= s1;
        end
    end

    // Drive the main levels and the inverted correction levels.
    always_comb begin
        out_i = s2.i;
        out_q = s2.q;
        pre_i = ~s1.i;
        pre_q = ~s1.q;
    end

    // R3
    lead_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ({out_i, out_q} == ~$past({pre_i, pre_q})));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable({out_i, out_q}) && $stable({pre_i, pre_q})));
endmodule

// File: rtl/qpsk_symbol_mux.sv
// Top of the QPSK symbol selector. At each symbol strobe it picks a dibit from the
// carrier level, the lead or lag pattern, the pseudo-random source or the external
// inputs, and passes it to the two-stage output registers.
// Assumes: the mode and the external inputs are valid in the strobe cycle.
module qpsk_symbol_mux
    import qsm_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 15'h0001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_en,
    input  logic [2:0] mode,
    input  logic       ext_i,
    input  logic       ext_q,
    output logic       out_i,
    output logic       out_q,
    output logic       pre_i,
    output logic       pre_q
);
    qsm_mode_e mode_e;
    dibit_t    prbs_d, rot_d, sel_d;
    logic      rot_run, rot_lag;

    // Decode the mode code; unused codes fall back to the carrier level.
    always_comb begin
        mode_e  = qsm_mode_e'(mode);
        rot_run = (mode_e == MODE_LEAD) || (mode_e == MODE_LAG);
        rot_lag = (mode_e == MODE_LAG);
    end

    qsm_prbs #(.SEED(SEED)) u_prbs (
        .clk(clk), .rst_n(rst_n), .adv(sym_en), .dib(prbs_d)
    );

    qsm_rotator u_rot (
        .clk(clk), .rst_n(rst_n), .adv(sym_en),
        .run(rot_run), .dir_lag(rot_lag), .dib(rot_d)
    );

    // Choose the source dibit for this symbol.
    always_comb begin
        case (mode_e)
            MODE_LEAD, MODE_LAG: sel_d = rot_d;
            MODE_PRBS:           sel_d = prbs_d;
            MODE_EXT:            sel_d = '{i: ext_i, q: ext_q};
            default:             sel_d = '0;
        endcase
    end

    qsm_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .adv(sym_en), .nxt(sel_d),
        .out_i(out_i), .out_q(out_q), .pre_i(pre_i), .pre_q(pre_q)
    );

    // R4
    carrier_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && (mode == 3'd0 || mode > 3'd4)) |=> ({pre_i, pre_q} == 2'b11));
endmodule

// File: tb/qpsk_symbol_mux_bench.sv
// Directed bench for qpsk_symbol_mux: one task per scenario.
module qpsk_symbol_mux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_en = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       ext_i = 1'b0;
    logic       ext_q = 1'b0;
    logic       out_i, out_q, pre_i, pre_q;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [14:0] mdl;

    qpsk_symbol_mux u_qpsk_symbol_mux (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .mode(mode),
        .ext_i(ext_i), .ext_q(ext_q),
        .out_i(out_i), .out_q(out_q), .pre_i(pre_i), .pre_q(pre_q)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sym_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge after the strobe edge.
    task automatic strobe(input logic [2:0] m, input logic i, input logic q);
        mode = m; ext_i = i; ext_q = q; sym_en = 1'b1;
        @(negedge clk);
        sym_en = 1'b0;
    endtask

    task automatic mdl_pair(output logic [1:0] d);
        for (int b = 0; b < 2; b++) begin
            d[1-b] = mdl[14];
            mdl = {mdl[13:0], mdl[14] ^ mdl[13]};
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 out in reset", {out_i, out_q}, 2'b00);
        chk("R1 pre in reset", {pre_i, pre_q}, 2'b11);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 out after release", {out_i, out_q}, 2'b00);
        chk("R1 pre after release", {pre_i, pre_q}, 2'b11);
    endtask

    task automatic t_external();
        logic [1:0] pat [8] = '{2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b10, 2'b01};
        logic [1:0] prev = 2'b00;
        for (int k = 0; k < 8; k++) begin
            strobe(3'd4, pat[k][1], pat[k][0]);
            chk("R9 R3 pre is inverse of current", {pre_i, pre_q}, ~pat[k]);
            chk("R3 out is previous symbol", {out_i, out_q}, prev);
            prev = pat[k];
            @(negedge clk);
        end
    endtask

    task automatic t_carrier();
        for (int c = 0; c < 4; c++) begin
            logic [2:0] m = (c == 0) ? 3'd0 : 3'(4 + c);
            strobe(3'd4, 1'b1, 1'b0);
            strobe(m, 1'b1, 1'b1);
            chk("R4 pre carrier level", {pre_i, pre_q}, 2'b11);
            strobe(m, 1'b0, 1'b1);
            chk("R4 out carrier level", {out_i, out_q}, 2'b00);
            chk("R4 pre stays at carrier", {pre_i, pre_q}, 2'b11);
        end
    endtask

    task automatic t_hold();
        strobe(3'd4, 1'b1, 1'b0);
        strobe(3'd4, 1'b0, 1'b1);
        mode = 3'd1; ext_i = 1'b1; ext_q = 1'b1;
        repeat (4) @(negedge clk);
        mode = 3'd3;
        repeat (3) @(negedge clk);
        chk("R2 out held between strobes", {out_i, out_q}, 2'b10);
        chk("R10 R2 pre held between strobes", {pre_i, pre_q}, 2'b10);
        mode = 3'd4; ext_i = 1'b0; ext_q = 1'b0;
        @(negedge clk);
        strobe(3'd4, 1'b1, 1'b1);
        chk("R10 only strobe-time inputs used", {pre_i, pre_q}, 2'b00);
        chk("R10 out follows prior strobe", {out_i, out_q}, 2'b01);
    endtask

    task automatic t_rotate(input logic lag);
        logic [1:0] seq [4];
        logic [1:0] prev = 2'b00;
        if (!lag) seq = '{2'b00, 2'b01, 2'b11, 2'b10};
        else      seq = '{2'b00, 2'b10, 2'b11, 2'b01};
        strobe(3'd0, 1'b0, 1'b0);
        strobe(3'd0, 1'b0, 1'b0);
        for (int k = 0; k < 9; k++) begin
            strobe(lag ? 3'd2 : 3'd1, 1'b1, 1'b0);
            if (!lag) begin
                chk("R5 lead pre", {pre_i, pre_q}, ~seq[k % 4]);
                chk("R5 lead out", {out_i, out_q}, prev);
            end else begin
                chk("R6 lag pre", {pre_i, pre_q}, ~seq[k % 4]);
                chk("R6 lag out", {out_i, out_q}, prev);
            end
            prev = seq[k % 4];
            @(negedge clk);
        end
    endtask

    task automatic t_prbs();
        logic [1:0] head [16];
        logic [1:0] d;
        logic [1:0] prev = 2'b00;
        do_reset();
        mdl = 15'h0001;
        for (int k = 1; k <= 32767 + 16; k++) begin
            strobe(3'd3, 1'b0, 1'b0);
            mdl_pair(d);
            if (k <= 40) begin
                chk("R7 prbs pre", {pre_i, pre_q}, ~d);
                chk("R7 prbs out", {out_i, out_q}, prev);
            end
            if (k <= 16) head[k-1] = ~{pre_i, pre_q};
            if (k > 32767) chk("R8 prbs period", ~{pre_i, pre_q}, head[k-32768]);
            prev = d;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_external();
        t_carrier();
        t_hold();
        t_rotate(1'b0);
        t_rotate(1'b1);
        t_prbs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule